// File: doc/BRIEF.md
# Countdown Interval Timer

A down-counting timer reached through a narrow memory-mapped register port. Software writes a reload value, starts the counter, and is told through a sticky timeout flag, an optional interrupt and an optional single-clock pulse each time the count passes through zero. On every zero the counter reloads the stored value. It then either keeps going (continuous mode) or halts (one-shot mode).

The counter is twice the port width (32 bits with the default 16-bit port), so it is split over two period halves. A snapshot mechanism lets software read it without tearing: any write to a snapshot register freezes the whole count into a shadow register, and both halves can then be read at leisure. Start and stop are write-event bits, so a control write never has to read-modify-write the run state. The reset period is a build-time parameter.

Top module: `tick_timer`

## Requirements
- R1: Register word offsets are 0 status, 1 control, 2 period low half, 3 period high half, 4 snapshot low half, 5 snapshot high half. Control bit 0 is interrupt enable and bit 1 is continuous mode; both read back. Bits 2 and 3 and all reserved bits read 0. Read data appears on `bus_rdata` on the clock edge that samples `bus_rd`.
- R2: After reset the period holds `PERIOD_INIT`, the counter equals it, the timer is stopped, the control bits and timeout flag are 0, and `irq` and `tmo_pulse` are low.
- R3: While running, the counter decrements once per clock. With stored value P, the timeout flag rises P+1 clocks after the edge that started the timer.
- R4: On the clock after the counter holds zero while running, the counter reloads the stored period. It keeps running if continuous mode is set, and otherwise it stops.
- R5: Status bit 0 (timeout) sets on each zero event and stays set until any write to the status register; a set in the same cycle wins. Status bit 1 (running) ignores writes.
- R6: `irq` is high exactly when the timeout flag and the interrupt enable are both 1; clearing either one drops it.
- R7: Writing 1 to control bit 2 (start) while stopped resumes counting from the value held in the counter. A 0 in bits 2 or 3 changes nothing, and a stopped counter holds its value.
- R8: Writing 1 to control bit 3 (stop) halts counting; if bits 2 and 3 are both 1 in one write, stop wins.
- R9: A write to either period half stores that half, loads the counter with the new full period, and stops the timer.
- R10: A write of any data to either snapshot offset copies the whole counter, as it stood before that edge, into both snapshot halves, running or not. Counting is not disturbed.
- R11: When enabled by `PULSE_EN`, `tmo_pulse` is high for the one clock that follows each zero event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register word offset |
| bus_wr | input | 1 | Write strobe, one access per high clock |
| bus_rd | input | 1 | Read strobe; data is registered on the same edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq | output | 1 | Interrupt request |
| tmo_pulse | output | 1 | One-clock pulse after each zero event |

## Verification
Counting is tried with a short one-shot period, with the same period in continuous mode, and with a period of 0x10000 whose count crosses the half boundary. The first pattern separates stop-after-zero from keep-running, and the second shows the reload repeating on a fixed spacing of P+1 clocks. The third exposes snapshot tearing and a wrong half order, and shows whether snapshot, stop and resume shift the count by even one clock. Register vectors cover the reset values, reserved-bit masking, start and stop together, and a period write landing in the counter.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

   // control register bit positions (software decodes these)
   localparam int CB_IEN   = 0;
   localparam int CB_CONT  = 1;
   localparam int CB_START = 2;
   localparam int CB_STOP  = 3;

   // status register bit positions
   localparam int SB_TMO   = 0;
   localparam int SB_RUN   = 1;

   // fixed word offsets; period and snapshot blocks follow
   localparam int ADR_STAT = 0;
   localparam int ADR_CTRL = 1;
   localparam int ADR_PER  = 2;

   typedef struct packed {
      logic cont;
      logic ien;
   } ctrl_t;

endpackage

// File: rtl/tick_timer_decode.sv
module tick_timer_decode #(
   parameter int HALVES = 2,
   parameter int ADDR_W = 3
) (
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   output logic              stat_wr,
   output logic              ctrl_wr,
   output logic [HALVES-1:0] per_wr,
   output logic              snap_wr
);
   import tick_timer_pkg::*;

   localparam int SNAP_BASE = ADR_PER + HALVES;
   localparam int SNAP_END  = SNAP_BASE + HALVES;

   assign stat_wr = bus_wr && (bus_addr == ADDR_W'(ADR_STAT));
   assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(ADR_CTRL));

   for (genvar i = 0; i < HALVES; i++) begin : g_per
      assign per_wr[i] = bus_wr && (bus_addr == ADDR_W'(ADR_PER + i));
   end

   assign snap_wr = bus_wr && (bus_addr >= ADDR_W'(SNAP_BASE))
                           && (bus_addr <  ADDR_W'(SNAP_END));

endmodule

// File: rtl/tick_timer_count.sv
module tick_timer_count #(
   parameter int              DATA_W      = 16,
   parameter int              HALVES      = 2,
   parameter longint unsigned PERIOD_INIT = 49999,
   localparam int             CNT_W       = DATA_W * HALVES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] wdata,
   input  logic [HALVES-1:0] per_wr,
   input  logic              ctrl_wr,
   input  logic              start,
   input  logic              stop,
   input  logic              cont,
   output logic [CNT_W-1:0]  cnt_q,
   output logic [CNT_W-1:0]  per_flat,
   output logic              run_q,
   output logic              evt
);

   logic [HALVES-1:0][DATA_W-1:0] per_q;
   logic [HALVES-1:0][DATA_W-1:0] per_nx;
   logic [CNT_W-1:0]              cnt_nx;
   logic                          run_nx;
   logic                          per_any;

   assign per_any  = |per_wr;
   assign per_flat = per_q;
   assign evt      = run_q && (cnt_q == '0) && !per_any;

   always_comb begin
      per_nx = per_q;
      for (int i = 0; i < HALVES; i++) begin
         if (per_wr[i]) per_nx[i] = wdata;
      end
   end

   always_comb begin
      cnt_nx = cnt_q;
      if (per_any)             cnt_nx = per_nx;
      else if (run_q) begin
         if (cnt_q == '0)      cnt_nx = per_q;
         else                  cnt_nx = cnt_q - 1'b1;
      end
   end

   always_comb begin
      run_nx = run_q;
      if (evt) run_nx = cont;
      if (ctrl_wr) begin
         if (stop)                run_nx = 1'b0;
         else if (start && !run_q) run_nx = 1'b1;
      end
      if (per_any) run_nx = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_q <= CNT_W'(PERIOD_INIT);
         cnt_q <= CNT_W'(PERIOD_INIT);
         run_q <= 1'b0;
      end else begin
         per_q <= per_nx;
         cnt_q <= cnt_nx;
         run_q <= run_nx;
      end
   end

   AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && cnt_q != '0 && !per_any) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R3
   AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && cnt_q == '0 && !per_any) |=> (cnt_q == per_flat)); // R4
   AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && !cont && !ctrl_wr) |=> !run_q); // R4
   AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !per_any) |=> $stable(cnt_q)); // R7
   AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && stop) |=> !run_q); // R8
   AST_PERWR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      per_any |=> (!run_q && cnt_q == per_flat)); // R9

endmodule

// File: rtl/tick_timer_snap.sv
module tick_timer_snap #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             snap_wr,
   input  logic             run,
   input  logic             per_any,
   input  logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] snap_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       snap_q <= '0;
      else if (snap_wr) snap_q <= cnt;
   end

   // a stopped, untouched counter must still equal the frozen copy
   AST_SNAP_COHERENT: assert property (@(posedge clk) disable iff (!rst_n)
      (snap_wr && !run && !per_any) |=> (snap_q == cnt)); // R10

endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
   parameter int              DATA_W      = 16,
   parameter int              HALVES      = 2,
   parameter longint unsigned PERIOD_INIT = 49999,
   parameter bit              PULSE_EN    = 1'b1,
   localparam int             CNT_W       = DATA_W * HALVES,
   localparam int             ADDR_W      = $clog2(2 + 2 * HALVES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq,
   output logic              tmo_pulse
);
   import tick_timer_pkg::*;

   localparam int SNAP_BASE = ADR_PER + HALVES;

   if (DATA_W < 4) begin : g_bad_width
      $error("tick_timer: DATA_W must hold the four control bits");
   end
   if (HALVES < 1 || CNT_W > 64) begin : g_bad_halves
      $error("tick_timer: counter must be 1..64 bits in whole halves");
   end

   logic              stat_wr, ctrl_wr, snap_wr;
   logic [HALVES-1:0] per_wr;
   logic [CNT_W-1:0]  cnt, per_flat, snap;
   logic              run, evt;
   ctrl_t             ctrl_q;
   logic              tmo_q;
   logic [DATA_W-1:0] rd_nx, rdata_q;

   tick_timer_decode #(
      .HALVES (HALVES),
      .ADDR_W (ADDR_W)
   ) u_decode (
      .bus_addr (bus_addr),
      .bus_wr   (bus_wr),
      .stat_wr  (stat_wr),
      .ctrl_wr  (ctrl_wr),
      .per_wr   (per_wr),
      .snap_wr  (snap_wr)
   );

   tick_timer_count #(
      .DATA_W      (DATA_W),
      .HALVES      (HALVES),
      .PERIOD_INIT (PERIOD_INIT)
   ) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .wdata    (bus_wdata),
      .per_wr   (per_wr),
      .ctrl_wr  (ctrl_wr),
      .start    (bus_wdata[CB_START]),
      .stop     (bus_wdata[CB_STOP]),
      .cont     (ctrl_q.cont),
      .cnt_q    (cnt),
      .per_flat (per_flat),
      .run_q    (run),
      .evt      (evt)
   );

   tick_timer_snap #(
      .CNT_W (CNT_W)
   ) u_snap (
      .clk     (clk),
      .rst_n   (rst_n),
      .snap_wr (snap_wr),
      .run     (run),
      .per_any (|per_wr),
      .cnt     (cnt),
      .snap_q  (snap)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (ctrl_wr) begin
         ctrl_q.ien  <= bus_wdata[CB_IEN];
         ctrl_q.cont <= bus_wdata[CB_CONT];
      end
   end

   // set beats clear when both land in one cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       tmo_q <= 1'b0;
      else if (evt)     tmo_q <= 1'b1;
      else if (stat_wr) tmo_q <= 1'b0;
   end

   assign irq = tmo_q & ctrl_q.ien;

   if (PULSE_EN) begin : g_pulse
      logic pulse_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pulse_q <= 1'b0;
         else        pulse_q <= evt;
      end
      assign tmo_pulse = pulse_q;

      AST_PULSE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
         tmo_pulse |-> tmo_q); // R11
   end else begin : g_no_pulse
      assign tmo_pulse = 1'b0;
   end

   always_comb begin
      rd_nx = '0;
      if (bus_addr == ADDR_W'(ADR_STAT)) begin
         rd_nx[SB_TMO] = tmo_q;
         rd_nx[SB_RUN] = run;
      end else if (bus_addr == ADDR_W'(ADR_CTRL)) begin
         rd_nx[CB_IEN]  = ctrl_q.ien;
         rd_nx[CB_CONT] = ctrl_q.cont;
      end
      for (int i = 0; i < HALVES; i++) begin
         if (bus_addr == ADDR_W'(ADR_PER + i))   rd_nx = per_flat[i*DATA_W +: DATA_W];
         if (bus_addr == ADDR_W'(SNAP_BASE + i)) rd_nx = snap[i*DATA_W +: DATA_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata_q <= '0;
      else if (bus_rd) rdata_q <= rd_nx;
   end

   assign bus_rdata = rdata_q;

   AST_TMO_SET: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> tmo_q); // R5
   AST_TMO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (tmo_q && !stat_wr) |=> tmo_q); // R5

endmodule

// File: tb/tick_timer_bench.sv
`timescale 1ns/1ps
module tick_timer_bench;

   localparam int A_STAT = 0, A_CTRL = 1, A_PLO = 2, A_PHI = 3, A_SLO = 4, A_SHI = 5;
   localparam int NVEC = 19;

   // {is_write, addr[2:0], wdata[15:0], expected[15:0], req[3:0]}
   localparam logic [39:0] VEC [NVEC] = '{
      {1'b0, 3'd0, 16'h0000, 16'h0000, 4'd2},  // R2 status
      {1'b0, 3'd1, 16'h0000, 16'h0000, 4'd2},  // R2 control
      {1'b0, 3'd2, 16'h0000, 16'h03E8, 4'd2},  // R2 period low
      {1'b0, 3'd3, 16'h0000, 16'h0000, 4'd2},  // R2 period high
      {1'b1, 3'd5, 16'h5A5A, 16'h0000, 4'd10}, // R10 snapshot via high offset
      {1'b0, 3'd4, 16'h0000, 16'h03E8, 4'd10}, // R10
      {1'b0, 3'd5, 16'h0000, 16'h0000, 4'd10}, // R10
      {1'b1, 3'd1, 16'hFFF3, 16'h0000, 4'd1},  // R1 reserved junk, no start/stop
      {1'b0, 3'd1, 16'h0000, 16'h0003, 4'd1},  // R1
      {1'b0, 3'd0, 16'h0000, 16'h0000, 4'd7},  // R7 zero start bit: still stopped
      {1'b1, 3'd1, 16'h000C, 16'h0000, 4'd8},  // R8 start and stop together
      {1'b0, 3'd0, 16'h0000, 16'h0000, 4'd8},  // R8
      {1'b0, 3'd1, 16'h0000, 16'h0000, 4'd1},  // R1 event bits read 0
      {1'b1, 3'd3, 16'h0000, 16'h0000, 4'd9},  // R9
      {1'b1, 3'd2, 16'h0004, 16'h0000, 4'd9},  // R9
      {1'b0, 3'd2, 16'h0000, 16'h0004, 4'd1},  // R1
      {1'b0, 3'd3, 16'h0000, 16'h0000, 4'd1},  // R1
      {1'b1, 3'd4, 16'h0000, 16'h0000, 4'd9},  // R9 counter loaded
      {1'b0, 3'd4, 16'h0000, 16'h0004, 4'd9}   // R9
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        irq, tmo_pulse;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   tick_timer #(
      .DATA_W      (16),
      .HALVES      (2),
      .PERIOD_INIT (1000),
      .PULSE_EN    (1'b1)
   ) u_tick_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq       (irq),
      .tmo_pulse (tmo_pulse)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // every bus task starts and ends at a falling edge and spans one rising edge
   task automatic wr(input int a, input logic [15:0] d);
      bus_addr = 3'(a); bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [15:0] d);
      bus_addr = 3'(a); bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      logic [15:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check("R2 irq", 32'(irq), 0);
      check("R2 pulse", 32'(tmo_pulse), 0);

      for (int v = 0; v < NVEC; v++) begin
         if (VEC[v][39]) wr(int'(VEC[v][38:36]), VEC[v][35:20]);
         else begin
            rd(int'(VEC[v][38:36]), d);
            check($sformatf("R%0d vector %0d", VEC[v][3:0], v), 32'(d), 32'(VEC[v][19:4]));
         end
      end

      // one-shot, stored period 4: flag after 5 clocks
      wr(A_CTRL, 16'h0005);
      idle(4);
      check("R3 no early timeout", 32'(irq), 0);
      check("R11 no early pulse", 32'(tmo_pulse), 0);
      idle(1);
      check("R6 irq on timeout", 32'(irq), 1);
      check("R11 pulse on timeout", 32'(tmo_pulse), 1);
      idle(1);
      check("R11 pulse one clock", 32'(tmo_pulse), 0);
      check("R5 flag sticky", 32'(irq), 1);
      rd(A_STAT, d);
      check("R4 one-shot stopped", 32'(d), 32'h0001);
      wr(A_SLO, 16'h0000);
      rd(A_SLO, d);
      check("R4 reloaded period", 32'(d), 32'h0004);
      wr(A_STAT, 16'h0000);
      check("R6 ack by status", 32'(irq), 0);
      rd(A_STAT, d);
      check("R5 flag cleared", 32'(d), 32'h0000);

      // continuous: zero events every 5 clocks
      wr(A_CTRL, 16'h0007);
      idle(5);
      check("R11 first pulse", 32'(tmo_pulse), 1);
      idle(1);
      check("R11 pulse ended", 32'(tmo_pulse), 0);
      idle(4);
      check("R4 continuous reload pulse", 32'(tmo_pulse), 1);
      rd(A_STAT, d);
      check("R4 still running", 32'(d), 32'h0003);
      wr(A_CTRL, 16'h0002);
      check("R6 ack by enable", 32'(irq), 0);
      rd(A_STAT, d);
      check("R7 zero event bits keep running", 32'(d), 32'h0003);
      wr(A_STAT, 16'hFFFF);
      rd(A_STAT, d);
      check("R5 run bit ignores write", 32'(d), 32'h0002);
      wr(A_CTRL, 16'h0008);
      rd(A_STAT, d);
      check("R8 stop halts", 32'(d), 32'h0001);

      // snapshot across the half boundary, period 0x10000
      wr(A_PHI, 16'h0001);
      wr(A_PLO, 16'h0000);
      wr(A_CTRL, 16'h0004);
      idle(3);
      wr(A_SHI, 16'h1234);
      rd(A_SLO, d);
      check("R10 running snapshot low", 32'(d), 32'h0000FFFD);
      rd(A_SHI, d);
      check("R10 running snapshot high", 32'(d), 32'h0000);
      wr(A_CTRL, 16'h0008);
      wr(A_SLO, 16'h0000);
      rd(A_SLO, d);
      check("R10 counting undisturbed", 32'(d), 32'h0000FFF9);
      wr(A_CTRL, 16'h0004);
      idle(1);
      wr(A_SLO, 16'h0000);
      rd(A_SLO, d);
      check("R7 resumed from held value", 32'(d), 32'h0000FFF8);
      wr(A_PLO, 16'h0002);
      rd(A_STAT, d);
      check("R9 period write stops", 32'(d), 32'h0001);
      wr(A_SLO, 16'h0000);
      rd(A_SLO, d);
      check("R9 counter loaded low", 32'(d), 32'h0002);
      rd(A_SHI, d);
      check("R9 counter loaded high", 32'(d), 32'h0001);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule